// File: doc/BRIEF.md
# Tree DEM Switching Node

This block is one node of a tree that picks which unit elements of a multibit feedback DAC are switched on. Every clock it receives an unsigned element count and divides it between two child branches as `(y+S)/2` and `(y-S)/2`. The signed steering value `S` moves one or two units from one branch to the other. It is chosen from the sign of a local second-order lowpass noise-shaping filter, and it is also the input to that filter. Over time the mismatch between the two branches is pushed out of the low-frequency band.

A node on layer `K` accepts counts from 0 to 2^K and produces two `K`-bit counts. Each cycle the node sorts its input into one of three step kinds. STEP_NONE covers a count at either end of the range. STEP_ONE covers an odd count. STEP_TWO covers an even count strictly inside the range. The kind decides the magnitude of `S`, and the filter sign decides its polarity. The kind is taken again from each new input, with no memory between cycles, so any kind can follow any other. The filter advances only on cycles where the node actually steers.

Top module: `tdem_switch_node`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both outputs to 0 and clears both integrators. The first steering decision after reset is therefore positive.
- R2: On each clock edge, `out_a + out_b` equals the `y_in` value sampled at that edge.
- R3: The steering value `S = out_a - out_b` has the same parity as `y`, and `|S| <= min(y, 2^K - y)`.
- R4: For odd `y`, `S` is +1 when the filter decision is positive and -1 when it is negative.
- R5: For even `y` with `0 < y < 2^K`, `S` is +2 when the decision is positive and -2 when it is negative.
- R6: For `y = 0` or `y = 2^K`, `S` is 0, so both outputs equal `y/2`. The integrators hold their values on such a cycle.
- R7: Let the integrators be `i1` and `i2`. On a steering cycle they update as `i1 <= i1 + S` and then `i2 <= i2 + (i1 + S)`. The decision is positive when `-(i1 + i2) >= 0`, so a value of exactly zero counts as positive.
- R8: Neither integrator wraps around in its `ACC_W`-bit signed range under any input sequence.
- R9: Outputs change only at a clock edge. The result for the `y_in` present at one edge appears after that edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| y_in | input | K+1 | Element count for this node, 0 to 2^K |
| out_a | output | K | Registered upper branch count, (y+S)/2 |
| out_b | output | K | Registered lower branch count, (y-S)/2 |

## Verification
The bench keeps its own model of the two integrators and the sign decision, and compares every output pair against it. This exposes a wrong polarity for a zero filter value, a swapped integrator order, or a filter that keeps running on a no-steer cycle: each of these makes the predicted split drift away from the observed one within a few steps. Runs made only of the two range ends check that the node sends exactly half of the count each way and then resumes with the decision it would have made before the run. Even counts inside the range must steer by two, so a design that steers by zero would stall the loop. Resets in the middle of a run, and a look at the outputs between edges, catch state that is not cleared and outputs that are not registered.

// File: rtl/tdem_pkg.sv
package tdem_pkg;
    // Kind of steering step taken on a cycle
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,   // y at either end of range, S = 0
        STEP_ONE  = 2'd1,   // odd y, |S| = 1
        STEP_TWO  = 2'd2    // even interior y, |S| = 2
    } step_e;

    localparam int STEER_W = 3;
endpackage

// File: rtl/tdem_quantizer.sv
module tdem_quantizer
    import tdem_pkg::*;
#(
    parameter int K = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [K:0]                y,
    input  logic                      fb_neg,
    output step_e                     kind,
    output logic signed [STEER_W-1:0] steer
);
    localparam logic [K:0] FULL_CNT = (K+1)'(1) << K;

    always_comb begin
        if (y == '0 || y == FULL_CNT)
            kind = STEP_NONE;
        else if (y[0])
            kind = STEP_ONE;
        else
            kind = STEP_TWO;
    end

    always_comb begin
        unique case (kind)
            STEP_NONE: steer = 3'sd0;
            STEP_ONE:  steer = fb_neg ? -3'sd1 : 3'sd1;
            STEP_TWO:  steer = fb_neg ? -3'sd2 : 3'sd2;
            default:   steer = 3'sd0;
        endcase
    end

    logic [STEER_W-1:0] steer_mag;
    assign steer_mag = steer[STEER_W-1] ? STEER_W'(-steer) : STEER_W'(steer);

    a_r3_parity: assert property (@(posedge clk) disable iff (rst)
        steer[0] == y[0]);
    a_r3_bound: assert property (@(posedge clk) disable iff (rst)
        ((K+1)'(steer_mag) <= y) && ((K+1)'(steer_mag) <= FULL_CNT - y));
    a_r5_interior_moves: assert property (@(posedge clk) disable iff (rst)
        (y != '0 && y != FULL_CNT) |-> steer != 3'sd0);
endmodule

// File: rtl/tdem_loop_filter.sv
module tdem_loop_filter
    import tdem_pkg::*;
#(
    parameter int ACC_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic signed [STEER_W-1:0] steer,
    output logic                      fb_neg
);
    logic signed [ACC_W-1:0] acc1_q, acc2_q;
    logic signed [ACC_W:0]   nxt1_w;
    logic signed [ACC_W+1:0] nxt2_w;
    logic signed [ACC_W:0]   tap_w;

    always_comb begin
        nxt1_w = (ACC_W+1)'(acc1_q) + (ACC_W+1)'(steer);
        nxt2_w = (ACC_W+2)'(acc2_q) + (ACC_W+2)'(nxt1_w);
        tap_w  = (ACC_W+1)'(acc1_q) + (ACC_W+1)'(acc2_q);
        // decision is the negated tap; zero counts as positive
        fb_neg = tap_w > 0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc1_q <= '0;
            acc2_q <= '0;
        end else if (en) begin
            acc1_q <= nxt1_w[ACC_W-1:0];
            acc2_q <= nxt2_w[ACC_W-1:0];
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        en |-> (nxt1_w[ACC_W] == nxt1_w[ACC_W-1]) &&
               (nxt2_w[ACC_W+1:ACC_W-1] == 3'b000 || nxt2_w[ACC_W+1:ACC_W-1] == 3'b111));
    a_r6_hold_state: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc1_q) && $stable(acc2_q));
endmodule

// File: rtl/tdem_splitter.sv
module tdem_splitter
    import tdem_pkg::*;
#(
    parameter int K = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [K:0]                y,
    input  logic signed [STEER_W-1:0] steer,
    output logic [K-1:0]              out_a,
    output logic [K-1:0]              out_b
);
    logic signed [K+1:0] up_w, dn_w, y_s, st_s;

    always_comb begin
        y_s  = $signed({1'b0, y});
        st_s = (K+2)'(steer);
        up_w = y_s + st_s;
        dn_w = y_s - st_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_a <= '0;
            out_b <= '0;
        end else begin
            out_a <= up_w[K:1];
            out_b <= dn_w[K:1];
        end
    end

    a_r3_even_split: assert property (@(posedge clk) disable iff (rst)
        !up_w[0] && !dn_w[0] && !up_w[K+1] && !dn_w[K+1]);
endmodule

// File: rtl/tdem_switch_node.sv
module tdem_switch_node
    import tdem_pkg::*;
#(
    parameter int K     = 3,
    parameter int ACC_W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [K:0]   y_in,
    output logic [K-1:0] out_a,
    output logic [K-1:0] out_b
);
    localparam logic [K:0] FULL_CNT = (K+1)'(1) << K;

    step_e                     kind;
    logic signed [STEER_W-1:0] steer;
    logic                      fb_neg;
    logic                      filt_en;

    assign filt_en = (kind != STEP_NONE);

    tdem_quantizer #(.K(K)) u_quant (
        .clk(clk), .rst(rst), .y(y_in), .fb_neg(fb_neg),
        .kind(kind), .steer(steer)
    );

    tdem_loop_filter #(.ACC_W(ACC_W)) u_filt (
        .clk(clk), .rst(rst), .en(filt_en), .steer(steer), .fb_neg(fb_neg)
    );

    tdem_splitter #(.K(K)) u_split (
        .clk(clk), .rst(rst), .y(y_in), .steer(steer),
        .out_a(out_a), .out_b(out_b)
    );

    logic [K:0]        out_sum;
    logic signed [K:0] out_diff;
    assign out_sum  = {1'b0, out_a} + {1'b0, out_b};
    assign out_diff = $signed({1'b0, out_a}) - $signed({1'b0, out_b});

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_a == '0 && out_b == '0));
    a_r2_conserve: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_sum == $past(y_in));
    a_r4_odd_unit: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(y_in[0])) |->
            (out_diff == (K+1)'(1) || out_diff == -(K+1)'(1)));
    a_r6_edge_even: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(y_in) == '0 || $past(y_in) == FULL_CNT)) |->
            out_a == out_b);
    a_r6_decision_frozen: assert property (@(posedge clk) disable iff (rst)
        (kind == STEP_NONE) |=> $stable(fb_neg));
endmodule

// File: tb/tb_tdem_switch_node.sv
module tb_tdem_switch_node;
    localparam int K     = 3;
    localparam int ACC_W = 12;
    localparam int FULL  = 1 << K;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [K:0]   y_in = '0;
    logic [K-1:0] out_a, out_b;

    int checks = 0;
    int fails  = 0;
    int m1 = 0, m2 = 0;
    int last_a = 0, last_b = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tdem_switch_node #(.K(K), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst(rst), .y_in(y_in), .out_a(out_a), .out_b(out_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pick_s(input int yv);
        int mag;
        if (yv == 0 || yv == FULL) return 0;
        mag = (yv % 2 == 1) ? 1 : 2;
        return ((m1 + m2) <= 0) ? mag : -mag;
    endfunction

    // one step: drive at negedge, check at next negedge
    task automatic apply(input int yv, input bit peek);
        int s, ea, eb, d, lim;
        string tag;
        s  = pick_s(yv);
        ea = (yv + s) / 2;
        eb = (yv - s) / 2;
        tag = (yv == 0 || yv == FULL) ? "R6" : ((yv % 2 == 1) ? "R4" : "R5");
        y_in = yv[K:0];
        if (peek) begin
            #5;
            check("R9 out_a before edge", int'(out_a), last_a);
            check("R9 out_b before edge", int'(out_b), last_b);
        end
        @(negedge clk);
        check({tag, " out_a"}, int'(out_a), ea);
        check({tag, " out_b"}, int'(out_b), eb);
        check("R2 conservation", int'(out_a) + int'(out_b), yv);
        d   = int'(out_a) - int'(out_b);
        lim = (yv < FULL - yv) ? yv : FULL - yv;
        check("R3 parity", ((d - yv) % 2 == 0) ? 1 : 0, 1);
        check("R3 bound", ((d <= lim) && (d >= -lim)) ? 1 : 0, 1);
        if (s != 0) begin
            m1 = m1 + s;
            m2 = m2 + m1;
        end
        last_a = ea;
        last_b = eb;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        y_in = '0;
        repeat (2) @(negedge clk);
        check("R1 out_a reset", int'(out_a), 0);
        check("R1 out_b reset", int'(out_b), 0);
        rst = 1'b0;
        m1 = 0; m2 = 0; last_a = 0; last_b = 0;
    endtask

    task automatic t_first_decision();
        // cleared filter -> positive: y=5 splits 3/2
        apply(5, 0);
        check("R1 first step out_a", int'(out_a), 3);
        check("R1 first step out_b", int'(out_b), 2);
    endtask

    task automatic t_odd_sweep();
        for (int i = 0; i < 24; i++) apply(2 * (i % 4) + 1, 0);
    endtask

    task automatic t_even_interior();
        for (int i = 0; i < 24; i++) apply(2 * (i % 3) + 2, 0);
        // after a positive step from zero state: y=4 on fresh filter tested in mid reset
    endtask

    task automatic t_edges();
        int s_before;
        s_before = pick_s(3);
        for (int i = 0; i < 10; i++) apply((i % 2 == 0) ? 0 : FULL, 0);
        apply(3, 0);
        check("R7 decision kept across edge run", int'(out_a) - int'(out_b), s_before);
    endtask

    task automatic t_latency();
        apply(7, 0);
        apply(FULL, 1);
        apply(2, 1);
    endtask

    task automatic t_long_mix();
        logic [15:0] lf = 16'hACE1;
        int worst = 0;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            apply(int'(lf % 16'd9), 0);
            if (m1 > worst) worst = m1;
            if (-m1 > worst) worst = -m1;
            if (m2 > worst) worst = m2;
            if (-m2 > worst) worst = -m2;
        end
        check("R8 model within accumulator range", (worst < (1 << (ACC_W - 1))) ? 1 : 0, 1);
        check("R7 long run tracked", fails, 0);
    endtask

    task automatic t_mid_reset();
        apply(6, 0);
        apply(1, 0);
        t_reset();
        apply(4, 0);
        check("R1 even after reset out_a", int'(out_a), 3);
        check("R5 even after reset out_b", int'(out_b), 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first_decision();
        t_odd_sweep();
        t_even_interior();
        t_edges();
        t_latency();
        t_long_mix();
        t_mid_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule